// File: doc/BRIEF.md
# CEC Transmit Holding Register with Clock-Domain Handoff

This block sits between a fast host register bus and the slow core clock (about 32.768 kHz, roughly 30.5 us per period) of a CEC controller. The host writes one 16-bit transmit block into a holding register. The block then crosses into the core domain through a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. While the crossing is in flight, bit 31 of the transmit register reads as a busy flag. The host polls that flag, not the interrupt, to decide when it may write the next block.

On the core side the captured block is offered to the bit-level transmitter on a valid/ready handshake. Once the transmitter takes it, a second toggle returns to the host domain and sets the transmit-empty status, which also drives the interrupt line. An optional control bit makes the hardware clear transmit-empty by itself, but only at the moment the crossing completes. A write to the transmit register while the busy flag is set is dropped and sets a sticky overrun status.

Register map (word address on `bus_addr`): 0 is transmit data plus busy flag, 1 is control, 2 is status (write-one-to-clear).

Top module: `cec_tx_handoff`

## Requirements
- R1: After reset, address 0 reads 0, status reads tx-empty (bit 0) = 1 and overrun (bit 1) = 0, control reads 0, `tx_irq` = 1 and `core_valid` = 0.
- R2: A write to address 0 while the busy flag is 0 stores write data bits 15:0. From the next host cycle, address 0 reads bit 31 = 1, bits 15:0 = stored data and bits 30:16 = 0, whatever was written to those bits.
- R3: The busy flag returns to 0 after the third core clock rising edge that follows the write and before the fifth.
- R4: `core_valid` is 1 with `core_data` equal to the stored block by the time the busy flag clears. Both `core_valid` and `core_data` hold unchanged while `core_ready` is 0, and `core_valid` drops after a core edge on which `core_ready` is 1.
- R5: A write to address 0 while the busy flag is 1 leaves the stored data and the core-side data unchanged and sets overrun (status bit 1). Overrun stays set until the host writes 1 to status bit 1.
- R6: With auto-clear off (control bit 29 = 0), tx-empty is not changed by the crossing. It is cleared only by writing 1 to status bit 0, and writing 0 there has no effect.
- R7: With auto-clear on (control bit 29 = 1), tx-empty stays 1 while the busy flag is 1. Hardware clears it in the same host cycle in which the busy flag clears.
- R8: Tx-empty is set to 1 within a few core cycles after the transmitter takes the block (`core_valid` and `core_ready` both 1 on a core edge), in either mode.
- R9: While the core side still holds an untaken block, a further written block is not captured. Its busy flag stays 1 until the earlier block has been taken and the new block has crossed.
- R10: `tx_irq` always equals the tx-empty status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| hrst_n | input | 1 | Host domain asynchronous reset, active low |
| bus_addr | input | 2 | Register word address for write and read |
| bus_wr | input | 1 | Write strobe, one host cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_irq | output | 1 | Transmit-empty interrupt |
| cclk | input | 1 | Slow CEC core clock |
| crst_n | input | 1 | Core domain asynchronous reset, active low |
| core_valid | output | 1 | A transmit block is offered to the transmitter |
| core_data | output | 16 | The offered transmit block |
| core_ready | input | 1 | Transmitter takes the offered block |

## Verification
The hardest case to reach is a block that finishes crossing while the core side still holds an earlier block the transmitter has not taken. The bench keeps `core_ready` low, lets one block cross, and then writes a second block. It waits many core cycles to show that the second block stays busy and is not captured. It then releases the first block and follows the second through its own crossing. The overrun path is reached by issuing two writes on consecutive host cycles, far faster than any crossing can finish. Busy time is measured in counted core clock edges, so the three-to-four-cycle window is checked exactly.

// File: rtl/cec_tx_handoff.sv
module cec_tx_handoff #(
  parameter int DATA_W   = 16,
  parameter int AUTO_BIT = 29,
  parameter int LOCK_BIT = 31
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_irq,
  input  logic              cclk,
  input  logic              crst_n,
  output logic              core_valid,
  output logic [DATA_W-1:0] core_data,
  input  logic              core_ready
);
  localparam int PAD_W = LOCK_BIT - DATA_W;

  logic [DATA_W-1:0] hold_q;
  logic lock_q, auto_q, empty_q, ovr_q, req_t;
  logic ak_s1, ak_s2, ak_seen, dn_s1, dn_s2, dn_seen;
  logic rq_s1, rq_s2, rq_seen, ack_t, done_t;

  wire tx_wr    = bus_wr && (bus_addr == 2'd0);
  wire ctl_wr   = bus_wr && (bus_addr == 2'd1);
  wire st_wr    = bus_wr && (bus_addr == 2'd2);
  wire ack_evt  = ak_s2 ^ ak_seen;
  wire done_evt = dn_s2 ^ dn_seen;

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      hold_q  <= '0;
      lock_q  <= 1'b0;
      auto_q  <= 1'b0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
      req_t   <= 1'b0;
      ak_s1   <= 1'b0;
      ak_s2   <= 1'b0;
      ak_seen <= 1'b0;
      dn_s1   <= 1'b0;
      dn_s2   <= 1'b0;
      dn_seen <= 1'b0;
    end else begin
      ak_s1   <= ack_t;
      ak_s2   <= ak_s1;
      ak_seen <= ak_s2;
      dn_s1   <= done_t;
      dn_s2   <= dn_s1;
      dn_seen <= dn_s2;
      if (ctl_wr) auto_q <= bus_wdata[AUTO_BIT];
      if (ack_evt) lock_q <= 1'b0;
      if (tx_wr && !lock_q) begin
        hold_q <= bus_wdata[DATA_W-1:0];
        req_t  <= ~req_t;
        lock_q <= 1'b1;
      end
      if (tx_wr && lock_q) ovr_q <= 1'b1;
      else if (st_wr && bus_wdata[1]) ovr_q <= 1'b0;
      if (done_evt) empty_q <= 1'b1;
      else if ((st_wr && bus_wdata[0]) || (auto_q && ack_evt)) empty_q <= 1'b0;
    end
  end

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      rq_s1      <= 1'b0;
      rq_s2      <= 1'b0;
      rq_seen    <= 1'b0;
      ack_t      <= 1'b0;
      done_t     <= 1'b0;
      core_valid <= 1'b0;
      core_data  <= '0;
    end else begin
      rq_s1 <= req_t;
      rq_s2 <= rq_s1;
      if (core_valid && core_ready) begin
        core_valid <= 1'b0;
        done_t     <= ~done_t;
      end else if (!core_valid && (rq_s2 ^ rq_seen)) begin
        core_data  <= hold_q;
        core_valid <= 1'b1;
        rq_seen    <= rq_s2;
        ack_t      <= ~ack_t;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {lock_q, {PAD_W{1'b0}}, hold_q};
      2'd1:    bus_rdata = 32'(auto_q) << AUTO_BIT;
      2'd2:    bus_rdata = {30'd0, ovr_q, empty_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign tx_irq = empty_q;

  assert_lock_rise_R2: assert property (@(posedge hclk) disable iff (!hrst_n)
    $rose(lock_q) |-> $past(tx_wr));
  assert_hold_frozen_R5: assert property (@(posedge hclk) disable iff (!hrst_n)
    lock_q |=> $stable(hold_q));
  assert_ovr_cause_R5: assert property (@(posedge hclk) disable iff (!hrst_n)
    $rose(ovr_q) |-> $past(tx_wr && lock_q));
  assert_auto_fall_R7: assert property (@(posedge hclk) disable iff (!hrst_n)
    $fell(empty_q) && !$past(st_wr && bus_wdata[0]) |-> $past(auto_q) && $fell(lock_q));
  assert_core_hold_R4: assert property (@(posedge cclk) disable iff (!crst_n)
    core_valid && !core_ready |=> core_valid && $stable(core_data));
endmodule

// File: tb/sim_cec_tx_handoff.sv
module sim_cec_tx_handoff;
  logic hclk = 0, cclk = 0, hrst_n = 0, crst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, core_ready = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_irq, core_valid;
  logic [15:0] core_data;
  int checks = 0, failures = 0, cedges = 0;

  cec_tx_handoff u0 (.hclk(hclk), .hrst_n(hrst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_irq(tx_irq), .cclk(cclk),
    .crst_n(crst_n), .core_valid(core_valid), .core_data(core_data), .core_ready(core_ready));

  always #10 hclk = ~hclk;
  initial begin #7; forever #200 cclk = ~cclk; end
  always @(posedge cclk) cedges++;

  localparam logic [16:0] VEC [0:3] = '{{1'b0, 16'hA55A}, {1'b1, 16'h0001},
                                        {1'b0, 16'hFFFF}, {1'b1, 16'h8000}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge hclk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge hclk); bus_wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    @(negedge hclk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_unlock(output int edges);
    logic [31:0] r;
    int start;
    start = cedges;
    for (int i = 0; i < 2000; i++) begin
      bread(2'd0, r);
      if (!r[31]) break;
    end
    edges = cedges - start;
  endtask

  task automatic accept();
    @(negedge cclk); core_ready = 1;
    @(negedge cclk); core_ready = 0;
    repeat (4) @(posedge cclk);
    repeat (3) @(negedge hclk);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int e;
    repeat (3) @(negedge hclk);
    hrst_n = 1; crst_n = 1;
    repeat (2) @(negedge hclk);
    // R1 reset state
    bread(2'd0, r); chk(r == 0, "R1 tx reg", r, 0);
    bread(2'd1, r); chk(r == 0, "R1 ctrl", r, 0);
    bread(2'd2, r); chk(r == 32'h1, "R1 status", r, 1);
    chk(tx_irq == 1 && core_valid == 0, "R1 irq/valid", {tx_irq, core_valid}, 2'b10);

    foreach (VEC[k]) begin
      logic au;
      logic [15:0] d;
      au = VEC[k][16]; d = VEC[k][15:0];
      bwrite(2'd1, 32'(au) << 29);
      bwrite(2'd0, 32'h5A5A_0000 | 32'(d));
      bread(2'd0, r); chk(r == {1'b1, 15'd0, d}, "R2 readback", r, {1'b1, 15'd0, d});
      bread(2'd2, r); chk(r[0] == 1, "R7 empty high while busy", r, 1);
      wait_unlock(e); chk(e >= 3 && e <= 4, "R3 busy core cycles", e, 3);
      bread(2'd2, r); chk(r[0] == !au, au ? "R7 auto clear" : "R6 no hw clear", r[0], !au);
      chk(tx_irq == r[0], "R10 irq follows status", tx_irq, r[0]);
      chk(core_valid && core_data == d, "R4 core data", core_data, d);
      if (!au) begin
        bwrite(2'd2, 32'h1); bread(2'd2, r);
        chk(r[0] == 0 && tx_irq == 0, "R6 w1c clear", r, 0);
      end
      repeat (3) @(posedge cclk); #1;
      chk(core_valid && core_data == d, "R4 hold while not ready", core_data, d);
      accept();
      chk(!core_valid, "R4 valid drops", core_valid, 0);
      bread(2'd2, r); chk(r[0] == 1 && tx_irq == 1, "R8 empty set on accept", r, 1);
    end

    // R6 writing 0 to status has no effect
    bwrite(2'd1, 0);
    bwrite(2'd2, 0); bread(2'd2, r); chk(r[0] == 1, "R6 write zero ignored", r, 1);

    // R5 overrun
    bwrite(2'd0, 32'h1234); bwrite(2'd0, 32'h5678);
    bread(2'd0, r); chk(r[15:0] == 16'h1234, "R5 data kept", r[15:0], 16'h1234);
    bread(2'd2, r); chk(r[1] == 1, "R5 overrun set", r, 2);
    wait_unlock(e);
    chk(core_data == 16'h1234, "R5 core data kept", core_data, 16'h1234);
    bread(2'd2, r); chk(r[1] == 1, "R5 overrun sticky", r, 2);
    bwrite(2'd2, 32'h2); bread(2'd2, r); chk(r[1] == 0, "R5 overrun w1c", r, 0);
    accept();

    // R9 second block waits for the first to be taken
    bwrite(2'd0, 32'h1111); wait_unlock(e);
    bwrite(2'd0, 32'h2222);
    repeat (10) @(posedge cclk);
    bread(2'd0, r); chk(r == {1'b1, 15'd0, 16'h2222}, "R9 still busy", r, {1'b1, 15'd0, 16'h2222});
    chk(core_data == 16'h1111, "R9 first block held", core_data, 16'h1111);
    accept();
    wait_unlock(e);
    bread(2'd0, r); chk(r[31] == 0, "R9 busy clears", r[31], 0);
    chk(core_valid && core_data == 16'h2222, "R9 second block", core_data, 16'h2222);
    bread(2'd2, r); chk(r[1] == 0, "R9 no overrun", r[1], 0);
    accept();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule